// File: doc/BRIEF.md
# Flash Region Lock and Command Sequencer

This block sits on a 32-bit peripheral register bus and guards every program and erase operation on a paged flash array. It keeps one lock bit per flash region, a boot-area protection count, a device security bit and a small bank of general-purpose nonvolatile bits. Software writes a command word naming an operation and its argument. The block checks the command against the protection state. It then either rejects the command with an error flag or drives the flash model through a timed sequence of one-cycle strobes.

Each strobe opens a step that lasts `STEP_CYC` clock cycles. Page program and page erase take one step. Whole-device erase takes three steps in a fixed order: wipe volatile memory, erase the whole array, then clear security. Lock, unlock, security and general-purpose bit commands change only internal state and finish in the cycle they are accepted. A completion flag and two error flags can each drive a level interrupt. All pins are plain control and status signals: the bus write takes effect in one cycle, and no data stream crosses the boundary.

Registers are word-addressed through `bus_addr[3:2]`: 0 = control, 1 = command, 2 = status, 3 = protection. A command word carries its opcode in bits [7:0] and its argument in bits [23:8].

Top module: `flash_guard`

## Requirements
- R1: A page belongs to region `page / (PAGES/REGIONS)`. A page program (opcode 0x01) or page erase (0x02) aimed at a locked region produces no strobe and no completion flag, and sets the lock-error flag (status bit 1).
- R2: Opcode 0x03 sets and opcode 0x04 clears the lock bit of the region in argument bits [RG_W-1:0], with no effect on the other bits. Lock bits read back in protection bits [REGIONS-1:0] and leave reset at `LOCK_INIT`.
- R3: Pages numbered below the boot count in control bits [8 +: PG_W+1] are rejected like locked pages. Writes to that field are ignored while the security bit is set.
- R4: Opcode 0x05 sets the security bit (status bit 4). No command except whole-device erase clears it.
- R5: Opcode 0x06 runs whatever the lock state. It pulses `vm_clear`, then `fl_erase_all`, then `sec_clear`, with each pulse `STEP_CYC` cycles after the one before it. It keeps `busy` high for 3*`STEP_CYC` cycles and clears the security bit as it finishes.
- R6: A permitted page program or erase gives exactly one pulse on `fl_prog` or `fl_erase`, with the target page on `fl_page`. It holds `busy` for `STEP_CYC` cycles and sets the done flag (status bit 0) at the end. At most one strobe is high in any cycle, and strobes appear only while busy.
- R7: An opcode outside 0x01..0x08 sets the programming-error flag (status bit 2), starts nothing and changes no protection state.
- R8: A command write accepted while `busy` is high is ignored entirely.
- R9: Opcode 0x07 writes argument bit 15 into general-purpose bit [argument bits GI_W-1:0]. Opcode 0x08 copies that bit to status bit 5. The general-purpose bits read back in protection bits [16 +: GP_BITS].
- R10: Status bits [2:0] are cleared by writing 1s to them. Successful register-only commands set the done flag at once. Status bit 3 mirrors `busy`.
- R11: `irq_rdy` is high when the done flag and control bit 0 are both set. `irq_err` is high when either error flag is set and control bit 1 is set.
- R12: After reset all flags, enables, the boot count, the security bit and the general-purpose bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable, used with bus_sel |
| bus_addr | input | 4 | Byte address, bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| busy | output | 1 | A flash sequence is running |
| fl_page | output | PG_W | Target page of the current program or erase |
| fl_prog | output | 1 | Page program strobe |
| fl_erase | output | 1 | Page erase strobe |
| fl_erase_all | output | 1 | Whole-array erase strobe |
| vm_clear | output | 1 | Volatile memory wipe strobe |
| sec_clear | output | 1 | Security clear strobe |
| irq_rdy | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench builds the block with 64 pages, 16 regions, 16 general-purpose bits and a three-cycle step. Each region then holds four pages, so random page numbers reach every region as well as both region edges. Boot counts of up to a dozen pages overlap the first three regions, which exercises the case where a lock and the boot protection both apply. The short step keeps whole-device erase cheap enough to run hundreds of times. Reset leaves regions 0 and 15 locked, so the lowest and highest regions start protected.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam logic [7:0] OPC_PGWR   = 8'h01;
  localparam logic [7:0] OPC_PGER   = 8'h02;
  localparam logic [7:0] OPC_LOCK   = 8'h03;
  localparam logic [7:0] OPC_UNLOCK = 8'h04;
  localparam logic [7:0] OPC_SETSEC = 8'h05;
  localparam logic [7:0] OPC_CHIPER = 8'h06;
  localparam logic [7:0] OPC_GPWR   = 8'h07;
  localparam logic [7:0] OPC_GPRD   = 8'h08;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_PROT = 2'd3;

  typedef enum logic [1:0] {JOB_PROG, JOB_ERASE, JOB_CHIP} job_e;
  typedef enum logic [2:0] {STP_IDLE, STP_PROG, STP_ERASE, STP_VMCLR, STP_ERALL, STP_SECCLR} step_e;
endpackage

// File: rtl/flg_lockbank.sv
module flg_lockbank #(
  parameter int PAGES = 256,
  parameter int REGIONS = 16,
  parameter logic [REGIONS-1:0] LOCK_INIT = '0,
  localparam int PG_W = $clog2(PAGES),
  localparam int RG_W = $clog2(REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [RG_W-1:0]   reg_idx,
  input  logic [PG_W-1:0]   page,
  input  logic [PG_W:0]     boot_cnt,
  output logic [REGIONS-1:0] locks,
  output logic              viol
);
  localparam int SH = PG_W - RG_W;

  logic [RG_W-1:0] page_reg;
  assign page_reg = RG_W'(page >> SH);

  for (genvar g = 0; g < REGIONS; g++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) locks[g] <= LOCK_INIT[g];
      else if (set_en && reg_idx == RG_W'(g)) locks[g] <= 1'b1;
      else if (clr_en && reg_idx == RG_W'(g)) locks[g] <= 1'b0;
    end
  end

  assign viol = locks[page_reg] | ({1'b0, page} < boot_cnt);
endmodule

// File: rtl/flg_seq.sv
module flg_seq
  import flg_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  job_e  job_in,
  output logic  busy,
  output step_e step,
  output logic  first,
  output logic  finish,
  output job_e  job
);
  localparam int CW = $clog2(STEP_CYC + 1);

  logic          busy_q;
  job_e          job_q;
  logic [1:0]    idx_q;
  logic [CW-1:0] cnt_q;
  logic          last, step_end;

  assign last     = (job_q == JOB_CHIP) ? (idx_q == 2'd2) : 1'b1;
  assign step_end = busy_q && (cnt_q == CW'(STEP_CYC - 1));
  assign finish   = step_end && last;
  assign first    = busy_q && (cnt_q == '0);
  assign busy     = busy_q;
  assign job      = job_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      job_q  <= JOB_PROG;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      job_q  <= job_in;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (step_end) begin
        cnt_q <= '0;
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + 2'd1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    step = STP_IDLE;
    if (busy_q) begin
      unique case (job_q)
        JOB_PROG:  step = STP_PROG;
        JOB_ERASE: step = STP_ERASE;
        default: begin
          if (idx_q == 2'd0)      step = STP_VMCLR;
          else if (idx_q == 2'd1) step = STP_ERALL;
          else                    step = STP_SECCLR;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flg_pkg::*;
#(
  parameter int PAGES = 256,
  parameter int REGIONS = 16,
  parameter int GP_BITS = 16,
  parameter int STEP_CYC = 4,
  parameter logic [REGIONS-1:0] LOCK_INIT = '0,
  localparam int PG_W = $clog2(PAGES),
  localparam int RG_W = $clog2(REGIONS),
  localparam int GI_W = $clog2(GP_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            busy,
  output logic [PG_W-1:0] fl_page,
  output logic            fl_prog,
  output logic            fl_erase,
  output logic            fl_erase_all,
  output logic            vm_clear,
  output logic            sec_clear,
  output logic            irq_rdy,
  output logic            irq_err
);
  localparam int BT_W = PG_W + 1;

  logic [1:0]  widx;
  logic        wr_ctrl, wr_cmd, wr_stat, accept;
  logic [7:0]  opc;
  logic [15:0] arg;
  assign widx    = bus_addr[3:2];
  assign wr_ctrl = bus_sel && bus_wr && widx == REG_CTRL;
  assign wr_cmd  = bus_sel && bus_wr && widx == REG_CMD;
  assign wr_stat = bus_sel && bus_wr && widx == REG_STAT;
  assign accept  = wr_cmd && !busy;
  assign opc     = bus_wdata[7:0];
  assign arg     = bus_wdata[23:8];

  logic            en_rdy_q, en_err_q, sec_q, done_q, lerr_q, perr_q, rdbit_q;
  logic [BT_W-1:0] boot_q;
  logic [GP_BITS-1:0] gp_q;
  logic [PG_W-1:0] page_q;
  logic [REGIONS-1:0] lock_q;

  // command decode
  logic known, is_page, is_chip, viol, start, imm_ok;
  job_e job_sel;
  always_comb begin
    known   = (opc >= OPC_PGWR) && (opc <= OPC_GPRD);
    is_page = (opc == OPC_PGWR) || (opc == OPC_PGER);
    is_chip = (opc == OPC_CHIPER);
    job_sel = is_chip ? JOB_CHIP : (opc == OPC_PGER) ? JOB_ERASE : JOB_PROG;
  end
  assign start  = accept && (is_chip || (is_page && !viol));
  assign imm_ok = accept && known && !is_page && !is_chip;

  flg_lockbank #(.PAGES(PAGES), .REGIONS(REGIONS), .LOCK_INIT(LOCK_INIT)) u_locks (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (accept && opc == OPC_LOCK),
    .clr_en   (accept && opc == OPC_UNLOCK),
    .reg_idx  (arg[RG_W-1:0]),
    .page     (arg[PG_W-1:0]),
    .boot_cnt (boot_q),
    .locks    (lock_q),
    .viol     (viol)
  );

  step_e step;
  job_e  job_run;
  logic  first, finish;
  flg_seq #(.STEP_CYC(STEP_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .job_in (job_sel),
    .busy   (busy),
    .step   (step),
    .first  (first),
    .finish (finish),
    .job    (job_run)
  );

  // strobes open each step
  assign fl_prog      = first && step == STP_PROG;
  assign fl_erase     = first && step == STP_ERASE;
  assign vm_clear     = first && step == STP_VMCLR;
  assign fl_erase_all = first && step == STP_ERALL;
  assign sec_clear    = first && step == STP_SECCLR;
  assign fl_page      = page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_rdy_q <= 1'b0;
      en_err_q <= 1'b0;
      boot_q   <= '0;
      page_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_rdy_q <= bus_wdata[0];
        en_err_q <= bus_wdata[1];
        if (!sec_q) boot_q <= bus_wdata[8 +: BT_W];
      end
      if (start) page_q <= arg[PG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= 1'b0;
      gp_q    <= '0;
      rdbit_q <= 1'b0;
    end else begin
      if (accept && opc == OPC_SETSEC) sec_q <= 1'b1;
      if (finish && job_run == JOB_CHIP) sec_q <= 1'b0;
      if (accept && opc == OPC_GPWR) gp_q[arg[GI_W-1:0]] <= arg[15];
      if (accept && opc == OPC_GPRD) rdbit_q <= gp_q[arg[GI_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      lerr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        if (bus_wdata[0]) done_q <= 1'b0;
        if (bus_wdata[1]) lerr_q <= 1'b0;
        if (bus_wdata[2]) perr_q <= 1'b0;
      end
      if (accept && !known) perr_q <= 1'b1;
      if (accept && is_page && viol) lerr_q <= 1'b1;
      if (imm_ok || finish) done_q <= 1'b1;
    end
  end

  assign irq_rdy = en_rdy_q && done_q;
  assign irq_err = en_err_q && (lerr_q || perr_q);

  always_comb begin
    bus_rdata = '0;
    unique case (widx)
      REG_CTRL: begin
        bus_rdata[0] = en_rdy_q;
        bus_rdata[1] = en_err_q;
        bus_rdata[8 +: BT_W] = boot_q;
      end
      REG_STAT: bus_rdata[5:0] = {rdbit_q, sec_q, busy, perr_q, lerr_q, done_q};
      REG_PROT: begin
        bus_rdata[REGIONS-1:0] = lock_q;
        bus_rdata[16 +: GP_BITS] = gp_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flg_chk.sv
module flg_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         prog,
  input logic         erase,
  input logic         erall,
  input logic         vmclr,
  input logic         secclr,
  input logic         sec_bit,
  input logic         lerr,
  input logic [N-1:0] locks
);
  logic seen_vm, seen_all;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_vm  <= 1'b0;
      seen_all <= 1'b0;
    end else if (!busy) begin
      seen_vm  <= 1'b0;
      seen_all <= 1'b0;
    end else begin
      if (vmclr) seen_vm <= 1'b1;
      if (erall) seen_all <= 1'b1;
    end
  end

  // R6
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog || erase || erall || vmclr || secclr) |-> busy);
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog, erase, erall, vmclr, secclr}));
  // R5
  erall_after_vm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erall |-> seen_vm);
  // R5
  secclr_after_erall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    secclr |-> seen_all);
  // R4
  sec_falls_from_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_bit) |-> $past(busy));
  // R8
  locks_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(locks));
  // R1
  lock_err_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lerr) |-> !busy);
endmodule

bind flash_guard flg_chk #(.N(REGIONS)) u_flg_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .prog    (fl_prog),
  .erase   (fl_erase),
  .erall   (fl_erase_all),
  .vmclr   (vm_clear),
  .secclr  (sec_clear),
  .sec_bit (sec_q),
  .lerr    (lerr_q),
  .locks   (lock_q)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;
  localparam int PAGES = 64;
  localparam int REGIONS = 16;
  localparam int GP_BITS = 16;
  localparam int STEP = 3;
  localparam logic [15:0] LINIT = 16'h8001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic busy, fl_prog, fl_erase, fl_erase_all, vm_clear, sec_clear, irq_rdy, irq_err;
  logic [5:0] fl_page;

  always #5 clk = ~clk;

  flash_guard #(.PAGES(PAGES), .REGIONS(REGIONS), .GP_BITS(GP_BITS),
                .STEP_CYC(STEP), .LOCK_INIT(LINIT)) i_flash_guard (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .fl_page(fl_page), .fl_prog(fl_prog), .fl_erase(fl_erase),
    .fl_erase_all(fl_erase_all), .vm_clear(vm_clear), .sec_clear(sec_clear),
    .irq_rdy(irq_rdy), .irq_err(irq_err));

  int total = 0, bad = 0;
  int log_q[$];

  // bench model
  logic [15:0] m_lock = LINIT, m_gp = '0;
  logic m_sec = 0, m_rd = 0, m_enr = 0, m_ene = 0;
  logic [6:0] m_boot = '0;
  logic m_done = 0, m_lerr = 0, m_perr = 0;

  always @(negedge clk) begin
    if (fl_prog)      log_q.push_back(256 + int'(fl_page));
    if (fl_erase)     log_q.push_back(512 + int'(fl_page));
    if (vm_clear)     log_q.push_back(768);
    if (fl_erase_all) log_q.push_back(1024);
    if (sec_clear)    log_q.push_back(1280);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wr_ctrl(input logic en_r, input logic en_e, input logic [6:0] bt);
    bw(4'h0, {16'h0, 1'b0, bt, 6'h0, en_e, en_r});
    m_enr = en_r; m_ene = en_e;
    if (!m_sec) m_boot = bt;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] st, pr, ct;
    br(4'h8, st);
    br(4'hC, pr);
    br(4'h0, ct);
    chk(st[2:0] == {m_perr, m_lerr, m_done}, {tag, " R10 flags"}, st[2:0], {m_perr, m_lerr, m_done});
    chk(st[4] == m_sec, {tag, " R4 security"}, st[4], m_sec);
    chk(st[5] == m_rd, {tag, " R9 gp read bit"}, st[5], m_rd);
    chk(pr[15:0] == m_lock, {tag, " R2 locks"}, pr[15:0], m_lock);
    chk(pr[31:16] == m_gp, {tag, " R9 gp bits"}, pr[31:16], m_gp);
    chk(ct[14:8] == m_boot, {tag, " R3 boot field"}, ct[14:8], m_boot);
    chk(irq_rdy == (m_enr && m_done), {tag, " R11 irq_rdy"}, irq_rdy, m_enr && m_done);
    chk(irq_err == (m_ene && (m_lerr || m_perr)), {tag, " R11 irq_err"}, irq_err,
        m_ene && (m_lerr || m_perr));
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [15:0] arg, input string tag);
    int exp_busy, bc;
    int exp_log[$];
    logic [5:0] pg;
    bw(4'h8, 32'h7);
    m_done = 0; m_lerr = 0; m_perr = 0;
    log_q.delete();
    exp_busy = 0;
    pg = arg[5:0];
    case (op)
      8'h01, 8'h02: begin
        if (m_lock[pg >> 2] || {1'b0, pg} < m_boot) m_lerr = 1;
        else begin
          exp_busy = STEP;
          exp_log.push_back((op == 8'h01 ? 256 : 512) + int'(pg));
          m_done = 1;
        end
      end
      8'h03: begin m_lock[arg[3:0]] = 1; m_done = 1; end
      8'h04: begin m_lock[arg[3:0]] = 0; m_done = 1; end
      8'h05: begin m_sec = 1; m_done = 1; end
      8'h06: begin
        exp_busy = 3 * STEP;
        exp_log.push_back(768); exp_log.push_back(1024); exp_log.push_back(1280);
        m_sec = 0; m_done = 1;
      end
      8'h07: begin m_gp[arg[3:0]] = arg[15]; m_done = 1; end
      8'h08: begin m_rd = m_gp[arg[3:0]]; m_done = 1; end
      default: m_perr = 1;
    endcase
    bw(4'h4, {8'h0, arg, op});
    bc = 0;
    while (busy && bc < 100) begin bc++; @(negedge clk); end
    chk(bc == exp_busy, {tag, " R6 busy length"}, bc, exp_busy);
    chk(log_q.size() == exp_log.size(), {tag, " R5 strobe count"}, log_q.size(), exp_log.size());
    foreach (exp_log[i])
      if (i < log_q.size())
        chk(log_q[i] == exp_log[i], {tag, " R5 strobe order"}, log_q[i], exp_log[i]);
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0, "R12 busy after reset", busy, 0);
    check_state("R12 reset");

    // directed: R1 locked region 0 and region 15
    do_cmd(8'h01, 16'd2, "R1 prog locked rgn0");
    do_cmd(8'h02, 16'd63, "R1 erase locked rgn15");
    do_cmd(8'h01, 16'd4, "R6 prog rgn1 edge");
    do_cmd(8'h02, 16'd59, "R6 erase rgn14 edge");
    // R2 unlock/lock
    do_cmd(8'h04, 16'd0, "R2 unlock rgn0");
    do_cmd(8'h01, 16'd0, "R6 prog page0");
    do_cmd(8'h03, 16'd7, "R2 lock rgn7");
    do_cmd(8'h02, 16'd28, "R1 erase rgn7 first page");
    // R3 boot protection
    wr_ctrl(1, 1, 7'd6);
    do_cmd(8'h01, 16'd5, "R3 boot page5");
    do_cmd(8'h01, 16'd6, "R3 first page past boot");
    // R4 security blocks boot field, chip erase clears
    do_cmd(8'h05, 16'd0, "R4 set security");
    wr_ctrl(1, 1, 7'd0);
    do_cmd(8'h02, 16'd1, "R3 boot kept under security");
    do_cmd(8'h06, 16'd0, "R5 chip erase");
    wr_ctrl(1, 1, 7'd0);
    // R7 illegal codes
    do_cmd(8'h00, 16'd3, "R7 opcode 00");
    do_cmd(8'h09, 16'd3, "R7 opcode 09");
    do_cmd(8'hFF, 16'hFFFF, "R7 opcode FF");
    // R9 gp bits
    do_cmd(8'h07, 16'h800F, "R9 gp write 15");
    do_cmd(8'h08, 16'h000F, "R9 gp read 15");
    // R8 command during busy is ignored
    bw(4'h8, 32'h7);
    m_done = 0; m_lerr = 0; m_perr = 0;
    bw(4'h4, {8'h0, 16'd0, 8'h06});
    bw(4'h4, {8'h0, 16'd5, 8'h03});
    bw(4'h4, {8'h0, 16'd0, 8'h33});
    while (busy) @(negedge clk);
    m_sec = 0; m_done = 1;
    check_state("R8 ignored while busy");
    // R10 W1C clears one flag only
    do_cmd(8'h44, 16'd0, "R10 setup");
    bw(4'h8, 32'h1);
    check_state("R10 w1c done only");
    bw(4'h8, 32'h4);
    m_perr = 0;
    check_state("R10 w1c prog err");

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int unsigned r;
      logic [15:0] a;
      r = $urandom % 11;
      a = 16'($urandom);
      case (r)
        0, 1: do_cmd(8'h01, {10'h0, a[5:0]}, "rnd prog");
        2:    do_cmd(8'h02, {10'h0, a[5:0]}, "rnd erase");
        3:    do_cmd(8'h03, a, "rnd lock");
        4, 5: do_cmd(8'h04, a, "rnd unlock");
        6:    do_cmd(8'h05, a, "rnd setsec");
        7:    do_cmd(8'h06, a, "rnd chip");
        8:    do_cmd((a[0] ? 8'h07 : 8'h08), a, "rnd gp");
        9:    wr_ctrl(a[0], a[1], 7'(a[11:8] % 12));
        default: do_cmd(8'(9 + ($urandom % 240)), a, "rnd illegal");
      endcase
    end
    check_state("final");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule